// File: doc/BRIEF.md
# RTC Status and Aging Trim Registers

This block holds the status byte and the crystal aging trim of a real-time clock. A simple register bus reaches it. The bus has an address, write data, a write strobe and combinational read data. Two addresses are decoded: the status byte at 0x0F and the aging trim at 0x10. Hardware events set sticky flags in the status byte: oscillator stopped, alarm 1 matched and alarm 2 matched. Software can only clear these flags, and only by writing 0. A write of 1 leaves a flag as it is.

The block also guards the temperature-compensation engine. A conversion request that arrives while no cycle is running issues one start pulse and sets a busy bit. Busy drops when the engine reports its idle state. While busy is set, further requests are dropped, so a running cycle is never aborted or restarted. The block also drives an active-low interrupt, the enable for the 32 kHz output, and the capacitance code sent to the oscillator array. That code is a base code plus the signed trim, saturated to its range.

Top module: `rtc_stat_trim`

## Requirements
- R1: The oscillator-stop flag (status bit 7) is 1 after reset. It becomes 1 in the cycle after `osc_stopped_i` is high, and it holds until software writes 0 to bit 7.
- R2: The alarm 1 flag (status bit 0) and the alarm 2 flag (status bit 1) are 0 after reset. Each is set in the cycle after its match input is high. A status write with that bit at 0 clears the flag, and a write with that bit at 1 leaves it unchanged.
- R3: If a flag's set input is high in the same cycle as a status write that would clear it, the flag ends up 1.
- R4: The 32 kHz enable (status bit 3) resets to 1 and can be written and read back freely. `clk32_en_o` always equals it.
- R5: A conversion request while busy (status bit 2) is 0 makes `conv_start_o` high for exactly the next cycle. Busy reads 1 from that cycle onward.
- R6: While busy is 1, conversion requests are ignored: `conv_start_o` stays 0 and busy stays 1.
- R7: Busy clears in the cycle after `tcxo_idle_i` is high while busy. Bus writes never change busy.
- R8: `int_n_o` is low exactly when `intcn_i` is 1 and at least one alarm flag is 1 together with its enable. It follows combinationally, so it rises in the same cycle a flag is cleared.
- R9: Address 0x10 holds an 8-bit trim that resets to 0 and reads back what was written. Status bits 6 to 4 read 0, and every other address reads 0. Writes to other addresses change neither register.
- R10: `cap_code_o` equals `base_cap_i` plus the trim read as two's complement. The sum is clamped to 0 and to 2^CAP_W-1. With CAP_REG=0 it is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| osc_stopped_i | input | 1 | Oscillator stopped event |
| alarm1_hit_i | input | 1 | Alarm 1 match pulse |
| alarm2_hit_i | input | 1 | Alarm 2 match pulse |
| alarm1_ie_i | input | 1 | Alarm 1 interrupt enable |
| alarm2_ie_i | input | 1 | Alarm 2 interrupt enable |
| intcn_i | input | 1 | Interrupt mode select |
| conv_req_i | input | 1 | Conversion request |
| tcxo_idle_i | input | 1 | Compensation engine entered idle |
| base_cap_i | input | CAP_W | Base capacitance code |
| int_n_o | output | 1 | Interrupt, active low |
| clk32_en_o | output | 1 | 32 kHz output enable |
| conv_start_o | output | 1 | Conversion start pulse |
| cap_code_o | output | CAP_W | Trimmed capacitance code |

## Verification
The hardest case to reach is the collision between a hardware set and a software clear on the same flag in the same cycle. The bench reaches it by raising all three event inputs on the exact negative half-cycle in which the clearing write is driven. A second hard case is a request that arrives in the same cycle as the engine's idle report while busy. The bench aligns those two inputs on one edge and then checks that no start pulse appears. The trim arithmetic is covered by sweeping every trim value against every base code. The flag write rules are covered by writing all 256 status patterns over a full set of flags.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
   localparam int STAT_OSF_BIT  = 7;
   localparam int STAT_EN32_BIT = 3;
   localparam int STAT_BUSY_BIT = 2;
   localparam int STAT_AL2_BIT  = 1;
   localparam int STAT_AL1_BIT  = 0;
   localparam int TRIM_W        = 8;
   localparam int NUM_FLAGS     = 3;
   // flag slots inside the sticky bank
   typedef enum int {FL_AL1 = 0, FL_AL2 = 1, FL_OSF = 2} flag_idx_e;
endpackage

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
   parameter int            N       = 3,
   parameter logic [N-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("rtc_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[i] <= RST_VAL[i];
         else if (set_i[i]) q_o[i] <= 1'b1;   // event beats clear
         else if (clr_i[i]) q_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_busy_ctl.sv
module rtc_busy_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic idle_i,
   output logic busy_o,
   output logic start_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         start_o <= 1'b0;
      end else if (busy_o) begin
         start_o <= 1'b0;
         if (idle_i) busy_o <= 1'b0;
      end else begin
         start_o <= req_i;
         if (req_i) busy_o <= 1'b1;
      end
   end
endmodule

// File: rtl/rtc_cap_adjust.sv
module rtc_cap_adjust #(
   parameter int CAP_W  = 8,
   parameter int TRIM_W = 8
) (
   input  logic [CAP_W-1:0]  base_i,
   input  logic [TRIM_W-1:0] trim_i,
   output logic [CAP_W-1:0]  code_o
);
   localparam int WIDE = ((CAP_W > TRIM_W) ? CAP_W : TRIM_W) + 2;

   logic signed [WIDE-1:0] base_s, trim_s, sum_s, top_s;

   always_comb begin
      base_s = $signed({{(WIDE-CAP_W){1'b0}}, base_i});
      trim_s = $signed({{(WIDE-TRIM_W){trim_i[TRIM_W-1]}}, trim_i});
      top_s  = $signed({{(WIDE-CAP_W){1'b0}}, {CAP_W{1'b1}}});
      sum_s  = base_s + trim_s;
      if (sum_s < 0)          code_o = '0;
      else if (sum_s > top_s) code_o = '1;
      else                    code_o = sum_s[CAP_W-1:0];
   end
endmodule

// File: rtl/rtc_stat_trim.sv
module rtc_stat_trim
   import rtc_stat_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0F,
   parameter logic [ADDR_W-1:0] TRIM_ADDR = 'h10,
   parameter int                CAP_W     = 8,
   parameter bit                CAP_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   output logic [7:0]        bus_rdata,
   input  logic              osc_stopped_i,
   input  logic              alarm1_hit_i,
   input  logic              alarm2_hit_i,
   input  logic              alarm1_ie_i,
   input  logic              alarm2_ie_i,
   input  logic              intcn_i,
   input  logic              conv_req_i,
   input  logic              tcxo_idle_i,
   input  logic [CAP_W-1:0]  base_cap_i,
   output logic              int_n_o,
   output logic              clk32_en_o,
   output logic              conv_start_o,
   output logic [CAP_W-1:0]  cap_code_o
);
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_aw
      $error("rtc_stat_trim: ADDR_W out of range");
   end
   if (CAP_W < 2 || CAP_W > 16) begin : g_bad_cw
      $error("rtc_stat_trim: CAP_W out of range");
   end
   if (STAT_ADDR == TRIM_ADDR) begin : g_bad_map
      $error("rtc_stat_trim: register addresses collide");
   end

   logic                 stat_wr, trim_wr;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
   logic                 en32_q, busy_q;
   logic [TRIM_W-1:0]    trim_q;
   logic [CAP_W-1:0]     cap_comb;

   assign stat_wr = bus_we && (bus_addr == STAT_ADDR);
   assign trim_wr = bus_we && (bus_addr == TRIM_ADDR);

   always_comb begin
      flag_set         = '0;
      flag_set[FL_AL1] = alarm1_hit_i;
      flag_set[FL_AL2] = alarm2_hit_i;
      flag_set[FL_OSF] = osc_stopped_i;
      flag_clr         = '0;
      flag_clr[FL_AL1] = stat_wr && !bus_wdata[STAT_AL1_BIT];
      flag_clr[FL_AL2] = stat_wr && !bus_wdata[STAT_AL2_BIT];
      flag_clr[FL_OSF] = stat_wr && !bus_wdata[STAT_OSF_BIT];
   end

   rtc_flag_bank #(
      .N       (NUM_FLAGS),
      .RST_VAL (NUM_FLAGS'(1) << FL_OSF)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (flag_clr),
      .q_o   (flag_q)
   );

   rtc_busy_ctl u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (conv_req_i),
      .idle_i  (tcxo_idle_i),
      .busy_o  (busy_q),
      .start_o (conv_start_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en32_q <= 1'b1;
         trim_q <= '0;
      end else begin
         if (stat_wr) en32_q <= bus_wdata[STAT_EN32_BIT];
         if (trim_wr) trim_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == STAT_ADDR) begin
         bus_rdata[STAT_OSF_BIT]  = flag_q[FL_OSF];
         bus_rdata[STAT_EN32_BIT] = en32_q;
         bus_rdata[STAT_BUSY_BIT] = busy_q;
         bus_rdata[STAT_AL2_BIT]  = flag_q[FL_AL2];
         bus_rdata[STAT_AL1_BIT]  = flag_q[FL_AL1];
      end else if (bus_addr == TRIM_ADDR) begin
         bus_rdata = trim_q;
      end
   end

   assign clk32_en_o = en32_q;
   assign int_n_o    = !(intcn_i && ((flag_q[FL_AL1] && alarm1_ie_i) ||
                                     (flag_q[FL_AL2] && alarm2_ie_i)));

   rtc_cap_adjust #(
      .CAP_W  (CAP_W),
      .TRIM_W (TRIM_W)
   ) u_cap (
      .base_i (base_cap_i),
      .trim_i (trim_q),
      .code_o (cap_comb)
   );

   if (CAP_REG) begin : g_cap_reg
      logic [CAP_W-1:0] cap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cap_q <= '0;
         else        cap_q <= cap_comb;
      end
      assign cap_code_o = cap_q;
   end else begin : g_cap_comb
      assign cap_code_o = cap_comb;
   end
endmodule

// File: rtl/rtc_stat_trim_chk.sv
module rtc_stat_trim_chk #(
   parameter int CAP_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       flag_q,
   input logic             busy_q,
   input logic             conv_start_o,
   input logic             tcxo_idle_i,
   input logic             osc_stopped_i,
   input logic             alarm1_hit_i,
   input logic             stat_wr,
   input logic             clr_bit0,
   input logic             int_n_o,
   input logic             intcn_i,
   input logic             alarm1_ie_i,
   input logic [7:0]       trim_q,
   input logic [CAP_W-1:0] base_cap_i,
   input logic [CAP_W-1:0] cap_comb
);
   assert_osf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stopped_i |=> flag_q[2]);

   assert_al1_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && clr_bit0 && !alarm1_hit_i) |=> !flag_q[0]);

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alarm1_hit_i |=> flag_q[0]);

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   assert_busy_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tcxo_idle_i) |=> (busy_q && !conv_start_o));

   assert_busy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && tcxo_idle_i) |=> !busy_q);

   assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (intcn_i && alarm1_ie_i && flag_q[0]) |-> !int_n_o);

   assert_zero_trim_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_q == 8'h00) |-> (cap_comb == base_cap_i));
endmodule

bind rtc_stat_trim rtc_stat_trim_chk #(.CAP_W(CAP_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flag_q        (flag_q),
   .busy_q        (busy_q),
   .conv_start_o  (conv_start_o),
   .tcxo_idle_i   (tcxo_idle_i),
   .osc_stopped_i (osc_stopped_i),
   .alarm1_hit_i  (alarm1_hit_i),
   .stat_wr       (stat_wr),
   .clr_bit0      (flag_clr[0]),
   .int_n_o       (int_n_o),
   .intcn_i       (intcn_i),
   .alarm1_ie_i   (alarm1_ie_i),
   .trim_q        (trim_q),
   .base_cap_i    (base_cap_i),
   .cap_comb      (cap_comb)
);

// File: tb/tb_rtc_stat_trim.sv
`timescale 1ns/1ps
module tb_rtc_stat_trim;
   localparam logic [7:0] SA = 8'h0F;
   localparam logic [7:0] TA = 8'h10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic       bus_we = 0, osc_stopped_i = 0, alarm1_hit_i = 0, alarm2_hit_i = 0;
   logic       alarm1_ie_i = 0, alarm2_ie_i = 0, intcn_i = 0, conv_req_i = 0, tcxo_idle_i = 0;
   logic [7:0] base_cap_i = '0, cap_code_o;
   logic       int_n_o, clk32_en_o, conv_start_o;
   int         errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   rtc_stat_trim dut (.*);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
   endtask

   function automatic int rd(input logic [7:0] a);
      bus_addr = a;
      return 0;
   endfunction

   task automatic read(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic pulse_events(input logic o, input logic a1, input logic a2);
      @(negedge clk);
      osc_stopped_i = o; alarm1_hit_i = a1; alarm2_hit_i = a2;
      @(negedge clk);
      osc_stopped_i = 0; alarm1_hit_i = 0; alarm2_hit_i = 0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int starts;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      read(SA, d);  check("R1 R2 R4 R7 reset status", d, 8'h88);
      read(TA, d);  check("R9 reset trim", d, 0);
      check("R4 reset enable", clk32_en_o, 1);
      check("R8 reset irq", int_n_o, 1);
      check("R5 reset start", conv_start_o, 0);

      // R9: other addresses read 0, writes elsewhere do nothing
      read(8'h00, d); check("R9 unmapped read", d, 0);
      read(8'h11, d); check("R9 unmapped read", d, 0);
      wr(8'h0E, 8'h00);
      wr(8'h11, 8'h55);
      read(SA, d); check("R9 stray write status", d, 8'h88);
      read(TA, d); check("R9 stray write trim", d, 0);

      // R2/R4/R1: full sweep of status writes over a full set of flags
      for (int w = 0; w < 256; w++) begin
         pulse_events(1, 1, 1);
         wr(SA, 8'(w));
         read(SA, d);
         check("R1 R2 R4 R9 status write", d,
               {w[7], 3'b000, w[3], 1'b0, w[1], w[0]});
         check("R4 enable pin", clk32_en_o, w[3]);
      end

      // R1: flag holds across writes of 1 and without events
      wr(SA, 8'h08);
      pulse_events(1, 0, 0);
      repeat (4) @(negedge clk);
      wr(SA, 8'h88);
      read(SA, d); check("R1 osf sticky", d, 8'h88);

      // R3: set and clear in the same cycle
      wr(SA, 8'h08);
      @(negedge clk);
      bus_addr = SA; bus_wdata = 8'h08; bus_we = 1;
      osc_stopped_i = 1; alarm1_hit_i = 1; alarm2_hit_i = 1;
      @(negedge clk);
      bus_we = 0; osc_stopped_i = 0; alarm1_hit_i = 0; alarm2_hit_i = 0;
      read(SA, d); check("R3 set beats clear", d, 8'h8B);

      // R8: every flag and enable combination
      for (int f = 0; f < 4; f++) begin
         wr(SA, 8'h08);
         pulse_events(0, f[0], f[1]);
         for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            alarm1_ie_i = e[0]; alarm2_ie_i = e[1]; intcn_i = e[2];
            #0.5;
            check("R8 irq level", int_n_o,
                  !(e[2] && ((f[0] && e[0]) || (f[1] && e[1]))));
         end
      end
      // R8: irq rises as soon as the flag is cleared
      pulse_events(0, 1, 0);
      @(negedge clk);
      alarm1_ie_i = 1; alarm2_ie_i = 0; intcn_i = 1;
      #0.5; check("R8 irq asserted", int_n_o, 0);
      @(negedge clk);
      bus_addr = SA; bus_wdata = 8'h08; bus_we = 1;
      @(posedge clk); #0.5;
      check("R8 irq release", int_n_o, 1);
      @(negedge clk); bus_we = 0;

      // R5: start from idle
      @(negedge clk);
      conv_req_i = 1;
      @(posedge clk); #0.5;
      check("R5 start pulse", conv_start_o, 1);
      read(SA, d); check("R5 busy set", d[2], 1);
      // R6: hold the request for several cycles
      starts = 0;
      repeat (6) begin
         @(posedge clk); #0.5;
         if (conv_start_o) starts++;
      end
      check("R6 no restart", starts, 0);
      @(negedge clk); conv_req_i = 0;
      read(SA, d); check("R6 busy held", d[2], 1);
      // R7: writes do not touch busy
      wr(SA, 8'h08);
      read(SA, d); check("R7 write 0 busy", d[2], 1);
      wr(SA, 8'hFF);
      read(SA, d); check("R7 write 1 busy", d[2], 1);
      // R7: request and idle together while busy, no start
      @(negedge clk);
      conv_req_i = 1; tcxo_idle_i = 1;
      @(posedge clk); #0.5;
      check("R6 no start on idle", conv_start_o, 0);
      read(SA, d); check("R7 busy cleared", d[2], 0);
      @(negedge clk);
      tcxo_idle_i = 0;
      @(posedge clk); #0.5;
      check("R5 next start", conv_start_o, 1);
      @(negedge clk); conv_req_i = 0;
      @(posedge clk); #0.5;
      check("R5 one cycle", conv_start_o, 0);
      @(negedge clk); tcxo_idle_i = 1;
      @(negedge clk); tcxo_idle_i = 0;
      read(SA, d); check("R7 busy idle", d[2], 0);
      // R7: idle while not busy does nothing
      @(negedge clk); tcxo_idle_i = 1;
      @(negedge clk); tcxo_idle_i = 0;
      read(SA, d); check("R7 idle when free", d[2], 0);
      check("R5 no spurious start", conv_start_o, 0);

      // R10 and R9: trim against every base code
      for (int o = 0; o < 256; o++) begin
         wr(TA, 8'(o));
         read(TA, d); check("R9 trim readback", d, o);
         for (int b = 0; b < 256; b++) begin
            int exp;
            base_cap_i = 8'(b);
            #0.5;
            exp = b + ((o > 127) ? o - 256 : o);
            if (exp < 0) exp = 0;
            if (exp > 255) exp = 255;
            check("R10 cap code", cap_code_o, exp);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule